// File: doc/BRIEF.md
# Two-Stage DAC Code Register Front End

This block is the digital side of an 8-bit voltage-output converter. A data byte passes through two register stages before it reaches the conversion core. The first stage is a staging register, written under an active-low select and an active-low write strobe. The second stage is the converter register. It copies the staging register under an active-low load strobe. Because the two strobes are separate, a new code can be staged while the old one is still on the output. The new code then reaches the output on a single load. If select, write and load are all held low, both stages follow the data bus, so the bus reaches the converter code one clock later.

An active-low reset forces the converter code to zero at once, whatever the strobes are doing. Assertion is asynchronous. Release is synchronised to the internal clock by a two-flop stage. The block also outputs a scaled estimate of the analog level in millivolts for a given reference. The code spans 256 steps from zero toward the reference.

A small control state machine tracks the mode for each clock:
- ST_RESET: entered asynchronously while reset is held.
- ST_HOLD: both stages keep their values.
- ST_WRITE: only the staging register takes the bus.
- ST_LOAD: only the converter register takes the staging value.
- ST_FLOW: both stages take the bus.

From ST_RESET, the first clock after release moves the machine to the mode decoded from the strobes. From any other state, every clock moves it to the decoded mode, and that includes staying in the same state. Reset returns it to ST_RESET from any state.

Top module: `dac_front_end`

## Requirements
- R1: While `rst_n` is low, `code` and `level` are 0 regardless of `cs_n`, `wr_n`, `ld_n` and `din`. This takes effect without waiting for a clock edge.
- R2: After `rst_n` rises, the first two rising clock edges still leave `code` at 0. The third rising edge is the first one that can load data.
- R3: On a rising edge with `ld_n` high, `code` keeps its value, even if the staging register is written in the same cycle.
- R4: On a rising edge with `ld_n` low and a staging write not enabled (`cs_n` or `wr_n` high), `code` takes the staging register value.
- R5: On a rising edge with `cs_n`, `wr_n` and `ld_n` all low, `code` takes `din` from that edge.
- R6: With `cs_n` high, `wr_n` low does not write the staging register, but `ld_n` low still loads the converter register from it.
- R7: When `cs_n` or `wr_n` is high on an edge, the staging register keeps its value. A later load shows the earlier byte, not the later bus value.
- R8: `level` equals floor(`code` × VREF_MV / 256). With VREF_MV = 5000, code 0xFF gives 4980 and code 0x80 gives 2500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all register updates occur on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous assert, release synchronised |
| cs_n | input | 1 | Active-low select gating staging register writes |
| wr_n | input | 1 | Active-low write strobe for the staging register |
| ld_n | input | 1 | Active-low load strobe for the converter register |
| din | input | 8 | Data bus byte |
| code | output | 8 | Code presented to the conversion core |
| level | output | 13 | Estimated output level in millivolts |

## Verification
A staging write and a converter load can fall on the same edge. In that case the converter must take the bus byte directly, not the old staging value. Vectors drive select, write and load low together right after a different byte was staged, and check that `code` equals the bus byte from that edge. Reset can also collide with all strobes active. Reset is pulled mid-cycle with the bus at full scale, and `code` must read zero before the next edge and through the two synchronised release edges.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_HOLD,
        ST_WRITE,
        ST_LOAD,
        ST_FLOW
    } fe_mode_e;
endpackage

// File: rtl/dac_fe_rst_sync.sv
module dac_fe_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_s
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_s = chain_q[STAGES-1];

    // R2: the synchronised release follows the raw release by two edges
    p_release_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_s) |-> $past(rst_n, 2));
endmodule

// File: rtl/dac_fe_ctrl.sv
module dac_fe_ctrl
    import dac_fe_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_s,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code
);
    fe_mode_e          state_q, state_nxt;
    logic              wr_en;
    logic [CODE_W-1:0] stage_q, conv_q;

    assign wr_en = !cs_n && !wr_n;

    always_comb begin
        unique case ({wr_en, !ld_n})
            2'b00:   state_nxt = ST_HOLD;
            2'b10:   state_nxt = ST_WRITE;
            2'b01:   state_nxt = ST_LOAD;
            default: state_nxt = ST_FLOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) begin
            stage_q <= '0;
            conv_q  <= '0;
        end else begin
            unique case (state_nxt)
                ST_WRITE: stage_q <= din;
                ST_LOAD:  conv_q  <= stage_q;
                ST_FLOW: begin
                    stage_q <= din;
                    conv_q  <= din;
                end
                default: ;
            endcase
        end
    end

    assign code = conv_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_s)
        ld_n |=> $stable(conv_q));
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_s)
        (!ld_n && (cs_n || wr_n)) |=> conv_q == $past(stage_q));
    p_flow_r5: assert property (@(posedge clk) disable iff (!rst_s)
        (state_q == ST_FLOW) |-> conv_q == $past(din));
    p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_s)
        (cs_n && !wr_n) |=> $stable(stage_q));
    p_latched_r7: assert property (@(posedge clk) disable iff (!rst_s)
        (cs_n || wr_n) |=> $stable(stage_q));
endmodule

// File: rtl/dac_fe_scale.sv
module dac_fe_scale #(
    parameter int CODE_W  = 8,
    parameter int VREF_MV = 5000,
    parameter int LVL_W   = $clog2(VREF_MV + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [LVL_W-1:0]  level
);
    localparam int PROD_W = CODE_W + LVL_W;
    logic [PROD_W-1:0] prod;

    assign prod  = PROD_W'(code) * PROD_W'(VREF_MV);
    assign level = prod[CODE_W +: LVL_W];

    // R8: estimate never reaches the reference
    always_comb begin
        assert (32'(level) < VREF_MV);
    end
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end #(
    parameter int CODE_W  = 8,
    parameter int VREF_MV = 5000,
    parameter int LVL_W   = $clog2(VREF_MV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code,
    output logic [LVL_W-1:0]  level
);
    logic rst_s;

    dac_fe_rst_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rst_s (rst_s)
    );

    dac_fe_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk   (clk),
        .rst_s (rst_s),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .ld_n  (ld_n),
        .din   (din),
        .code  (code)
    );

    dac_fe_scale #(.CODE_W(CODE_W), .VREF_MV(VREF_MV), .LVL_W(LVL_W)) u_scale (
        .code  (code),
        .level (level)
    );

    // R1: code sampled away from the edge is zero while reset is held
    p_reset_zero_r1: assert property (@(negedge clk)
        !rst_n |-> code == '0);
endmodule

// File: tb/sim_dac_front_end.sv
module sim_dac_front_end;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, wr_n, ld_n;
    logic [7:0] din;
    logic [7:0] code;
    logic [12:0] level;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dac_front_end u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
        .din(din), .code(code), .level(level)
    );

    // {cs_n, wr_n, ld_n, din, expected code}
    localparam int NV = 12;
    localparam logic [18:0] VEC [NV] = '{
        {3'b001, 8'hA5, 8'h00},  // R3 staged, code held
        {3'b110, 8'h33, 8'hA5},  // R4 load staged byte
        {3'b000, 8'h5A, 8'h5A},  // R5 flow
        {3'b011, 8'hFF, 8'h5A},  // R7 wr high, no stage change
        {3'b110, 8'h77, 8'h5A},  // R7 load shows earlier byte
        {3'b001, 8'h11, 8'h5A},  // R3 stage 0x11
        {3'b100, 8'hC3, 8'h11},  // R6 cs high: blocked write, load acts
        {3'b110, 8'h99, 8'h11},  // R6 staging still 0x11
        {3'b000, 8'hFF, 8'hFF},  // R5 full scale
        {3'b000, 8'h00, 8'h00},  // R5 zero
        {3'b000, 8'h80, 8'h80},  // R5 mid scale
        {3'b111, 8'h01, 8'h80}   // R3 idle hold
    };

    function automatic logic [12:0] exp_level(input logic [7:0] c);
        return 13'((32'(c) * 5000) / 256);
    endfunction

    task automatic check(input string req, input logic [7:0] exp_c);
        total++;
        if (code !== exp_c) begin
            bad++;
            $display("FAIL %s code actual=%h expected=%h", req, code, exp_c);
        end
        total++;
        if (level !== exp_level(exp_c)) begin
            bad++;
            $display("FAIL R8 level actual=%0d expected=%0d", level, exp_level(exp_c));
        end
    endtask

    task automatic step(input logic [2:0] ctl, input logic [7:0] d);
        @(negedge clk);
        {cs_n, wr_n, ld_n} = ctl;
        din = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0; din = 8'hEE;
        #1;
        check("R1 initial", 8'h00);
        repeat (3) @(posedge clk);
        #2;
        check("R1 held with strobes low", 8'h00);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R2 idle after release", 8'h00);
        check("R8 zero", 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18:16], VEC[i][15:8]);
            check($sformatf("R3-R7 vector %0d", i), VEC[i][7:0]);
        end

        // R1: asynchronous reset mid-cycle, bus at full scale, all strobes low
        step(3'b000, 8'hFF);
        check("R5 prior to reset", 8'hFF);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R1 async clear", 8'h00);
        @(posedge clk);
        #2;
        check("R1 held over edge", 8'h00);

        // R2: release with all strobes low, count edges
        @(negedge clk);
        din = 8'h3C;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R2 first edge", 8'h00);
        @(posedge clk);
        #2;
        check("R2 second edge", 8'h00);
        @(posedge clk);
        #2;
        check("R2 third edge loads", 8'h3C);

        // R4: staging was written through flow; load alone gives same byte
        step(3'b011, 8'h00);
        step(3'b110, 8'h00);
        check("R4 load after flow", 8'h3C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule